// File: doc/BRIEF.md
# Register Window Address Generator

This block turns register numbers into on-chip RAM addresses for a processor whose sixteen word-wide general-purpose registers are not flip-flops but a window into internal data RAM. A base pointer register marks where the active window starts, and software moves the window by writing a new base. Windows at different bases may share words, so a caller can leave arguments in its high registers and a callee can see them in its low ones. Banks may sit anywhere in the internal RAM, and their number is limited only by the space there.

Each cycle the block accepts up to two read requests and one write request, each a 4-bit register number with an enable. One cycle later it presents a RAM-relative word address and a strobe for each request. The byte address of register n is base + 2n. A request whose byte address falls outside the internal RAM window gets no strobe, and an error flag is raised instead. The RAM array, hazard handling and operand selection belong to the surrounding pipeline.

Top module: `gpr_window`

## Requirements
- R1: After reset all three strobes and the error flag are low and the base pointer reads RAM_BASE (default 0xF600).
- R2: A read on port A with register n at base cp gives, one cycle later, ramRdEnA high and ramRdAddrA = (cp + 2n - RAM_BASE) / 2.
- R3: Port B works by the same rule as port A, independently and in the same cycle, on ramRdEnB and ramRdAddrB.
- R4: A write request with register n gives, one cycle later, ramWrEn high and ramWrAddr = (cp + 2n - RAM_BASE) / 2.
- R5: A base pointer write stores the written value with bit 0 cleared, and cpValue shows it from the next cycle on.
- R6: Requests made in the same cycle as a base pointer write use the old base; requests from the next cycle on use the new base.
- R7: A request whose byte address cp + 2n is below RAM_BASE, at or above RAM_BASE + RAM_BYTES (default 0xFE00), or past the top of the 16-bit address space gets no strobe one cycle later, and rangeErr is high in that cycle; in-range requests of the same cycle still issue.
- R8: A cycle without requests leaves all strobes and rangeErr low in the next cycle.
- R9: Overlapping windows alias: register n at base cp and register n - k at base cp + 2k give the same RAM word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rdEnA | input | 1 | Read request, port A |
| rdIdxA | input | 4 | Register number, port A |
| rdEnB | input | 1 | Read request, port B |
| rdIdxB | input | 4 | Register number, port B |
| wrEn | input | 1 | Write request |
| wrIdx | input | 4 | Register number for the write |
| cpWrEn | input | 1 | Load the base pointer |
| cpWrData | input | 16 | New base pointer byte address |
| ramRdEnA | output | 1 | RAM read strobe, port A |
| ramRdAddrA | output | 10 | RAM word address, port A |
| ramRdEnB | output | 1 | RAM read strobe, port B |
| ramRdAddrB | output | 10 | RAM word address, port B |
| ramWrEn | output | 1 | RAM write strobe |
| ramWrAddr | output | 10 | RAM word address for the write |
| cpValue | output | 16 | Current base pointer |
| rangeErr | output | 1 | A request in the previous cycle fell outside the RAM |

## Verification
Every strobe, address and the error flag are due exactly one clock edge after the request, and cpValue changes at the same edge as a base pointer write. The driver applies a request at a falling edge and queues the expected result; the monitor pops one entry just after each rising edge, so every entry is compared at the edge where it is due. Addresses are compared only when a strobe is expected. The same-cycle base write case checks that the queued entry was built with the old base and the following one with the new.

// File: rtl/gpr_win_pkg.sv
package gpr_win_pkg;
  localparam int NUM_PORTS = 3;  // 0: read A, 1: read B, 2: write

  typedef struct packed {
    logic                 ldCp;
    logic [NUM_PORTS-1:0] issue;
    logic                 flagErr;
  } winStrobes_t;
endpackage

// File: rtl/gpr_win_ctrl.sv
module gpr_win_ctrl
  import gpr_win_pkg::*;
(
  input  logic [NUM_PORTS-1:0] reqEn,
  input  logic [NUM_PORTS-1:0] inRange,
  input  logic                 cpWrEn,
  output winStrobes_t          strb
);
  // Requests inside the RAM are issued; any enabled request outside it flags an error.
  always_comb begin
    strb.ldCp    = cpWrEn;
    strb.issue   = reqEn & inRange;
    strb.flagErr = |(reqEn & ~inRange);
  end
endmodule

// File: rtl/gpr_win_datapath.sv
module gpr_win_datapath
  import gpr_win_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          IDX_W     = 4,
  parameter int unsigned RAM_BASE  = 32'hF600,
  parameter int unsigned RAM_BYTES = 2048,
  parameter int unsigned RESET_CP  = RAM_BASE,
  parameter int          WORD_W    = $clog2(RAM_BYTES / 2)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  winStrobes_t          strb,
  input  logic [ADDR_W-1:0]    cpWrData,
  input  logic [IDX_W-1:0]     idx [NUM_PORTS],
  output logic [NUM_PORTS-1:0] inRange,
  output logic [WORD_W-1:0]    wordAddrQ [NUM_PORTS],
  output logic [NUM_PORTS-1:0] strobeQ,
  output logic                 errQ,
  output logic [ADDR_W-1:0]    cpValue
);
  localparam logic [ADDR_W:0] LoBound = (ADDR_W+1)'(RAM_BASE);
  localparam logic [ADDR_W:0] HiBound = (ADDR_W+1)'(RAM_BASE + RAM_BYTES);

  logic [ADDR_W-1:0] cpReg;

  // Base pointer, kept word aligned
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cpReg <= ADDR_W'(RESET_CP);
    else if (strb.ldCp) cpReg <= cpWrData & ~ADDR_W'(1);
  end
  assign cpValue = cpReg;

  a_r5_cp_aligned: assert property (@(posedge clk) disable iff (!rstN) !cpReg[0]);
  a_r6_cp_holds: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.ldCp) |-> $stable(cpReg));

  // One address lane per request port
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
    logic [ADDR_W:0] byteAddr;
    assign byteAddr   = {1'b0, cpReg} + {{(ADDR_W-IDX_W){1'b0}}, idx[p], 1'b0};
    assign inRange[p] = (byteAddr >= LoBound) && (byteAddr < HiBound);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wordAddrQ[p] <= '0;
        strobeQ[p]   <= 1'b0;
      end else begin
        strobeQ[p] <= strb.issue[p];
        if (strb.issue[p]) wordAddrQ[p] <= WORD_W'((byteAddr - LoBound) >> 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= strb.flagErr;
  end
endmodule

// File: rtl/gpr_window.sv
module gpr_window
  import gpr_win_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          IDX_W     = 4,
  parameter int unsigned RAM_BASE  = 32'hF600,
  parameter int unsigned RAM_BYTES = 2048,
  parameter int unsigned RESET_CP  = RAM_BASE,
  parameter int          WORD_W    = $clog2(RAM_BYTES / 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEnA,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic              rdEnB,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              cpWrEn,
  input  logic [ADDR_W-1:0] cpWrData,
  output logic              ramRdEnA,
  output logic [WORD_W-1:0] ramRdAddrA,
  output logic              ramRdEnB,
  output logic [WORD_W-1:0] ramRdAddrB,
  output logic              ramWrEn,
  output logic [WORD_W-1:0] ramWrAddr,
  output logic [ADDR_W-1:0] cpValue,
  output logic              rangeErr
);
  winStrobes_t          strb;
  logic [NUM_PORTS-1:0] inRange;
  logic [NUM_PORTS-1:0] strobeQ;
  logic [IDX_W-1:0]     idx [NUM_PORTS];
  logic [WORD_W-1:0]    wordAddrQ [NUM_PORTS];

  assign idx[0] = rdIdxA;
  assign idx[1] = rdIdxB;
  assign idx[2] = wrIdx;

  gpr_win_ctrl u_ctrl (
    .reqEn   ({wrEn, rdEnB, rdEnA}),
    .inRange (inRange),
    .cpWrEn  (cpWrEn),
    .strb    (strb)
  );

  gpr_win_datapath #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .RAM_BASE(RAM_BASE),
    .RAM_BYTES(RAM_BYTES), .RESET_CP(RESET_CP), .WORD_W(WORD_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cpWrData  (cpWrData),
    .idx       (idx),
    .inRange   (inRange),
    .wordAddrQ (wordAddrQ),
    .strobeQ   (strobeQ),
    .errQ      (rangeErr),
    .cpValue   (cpValue)
  );

  assign ramRdEnA   = strobeQ[0];
  assign ramRdEnB   = strobeQ[1];
  assign ramWrEn    = strobeQ[2];
  assign ramRdAddrA = wordAddrQ[0];
  assign ramRdAddrB = wordAddrQ[1];
  assign ramWrAddr  = wordAddrQ[2];

  a_r2_rd_a_requested: assert property (@(posedge clk) disable iff (!rstN)
    ramRdEnA |-> $past(rdEnA));
  a_r3_rd_b_requested: assert property (@(posedge clk) disable iff (!rstN)
    ramRdEnB |-> $past(rdEnB));
  a_r4_wr_requested: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> $past(wrEn));
  a_r7_err_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    rangeErr |-> $past(rdEnA || rdEnB || wrEn));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdEnA || rdEnB || wrEn) |-> !(ramRdEnA || ramRdEnB || ramWrEn || rangeErr));
endmodule

// File: tb/gpr_window_tb.sv
module gpr_window_tb;
  localparam int unsigned BASE  = 32'hF600;
  localparam int unsigned BYTES = 2048;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdEnA = 0, rdEnB = 0, wrEn = 0, cpWrEn = 0;
  logic [3:0] rdIdxA = 0, rdIdxB = 0, wrIdx = 0;
  logic [15:0] cpWrData = 0;
  logic ramRdEnA, ramRdEnB, ramWrEn, rangeErr;
  logic [9:0] ramRdAddrA, ramRdAddrB, ramWrAddr;
  logic [15:0] cpValue;

  always #2 clk = ~clk;  // 250 MHz

  gpr_window u_dut (
    .clk(clk), .rstN(rstN),
    .rdEnA(rdEnA), .rdIdxA(rdIdxA), .rdEnB(rdEnB), .rdIdxB(rdIdxB),
    .wrEn(wrEn), .wrIdx(wrIdx), .cpWrEn(cpWrEn), .cpWrData(cpWrData),
    .ramRdEnA(ramRdEnA), .ramRdAddrA(ramRdAddrA),
    .ramRdEnB(ramRdEnB), .ramRdAddrB(ramRdAddrB),
    .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr),
    .cpValue(cpValue), .rangeErr(rangeErr)
  );

  typedef struct {
    logic [2:0]  en;
    logic [9:0]  addr [3];
    logic        err;
    logic [15:0] cp;
    string       tag;
  } expItem_t;

  expItem_t    sbq[$];
  int          nCmp = 0, nBad = 0;
  logic [15:0] modelCp = 16'(BASE);
  bit          monOn = 0;

  task automatic check(string tag, string what, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void laneModel(input logic en, input logic [3:0] n,
                                    output logic issue, output logic bad,
                                    output logic [9:0] wa);
    int unsigned b;
    b = int'(modelCp) + 2 * int'(n);
    issue = en && b >= BASE && b < BASE + BYTES;
    bad   = en && !issue;
    wa    = 10'((b - BASE) / 2);
  endfunction

  // Driver: apply one cycle of requests and queue what is due at the next edge
  task automatic drive(input logic a, input logic [3:0] ia, input logic b, input logic [3:0] ib,
                       input logic w, input logic [3:0] iw, input logic c, input logic [15:0] cd,
                       input string tag);
    expItem_t e;
    logic     bad0, bad1, bad2;
    @(negedge clk);
    rdEnA = a; rdIdxA = ia; rdEnB = b; rdIdxB = ib;
    wrEn = w; wrIdx = iw; cpWrEn = c; cpWrData = cd;
    laneModel(a, ia, e.en[0], bad0, e.addr[0]);
    laneModel(b, ib, e.en[1], bad1, e.addr[1]);
    laneModel(w, iw, e.en[2], bad2, e.addr[2]);
    e.err = bad0 | bad1 | bad2;
    if (c) modelCp = cd & 16'hFFFE;
    e.cp  = modelCp;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // Monitor: compare just after each rising edge
  always @(posedge clk) begin
    #1;
    if (monOn && sbq.size() > 0) begin
      expItem_t e;
      e = sbq.pop_front();
      check(e.tag, "ramRdEnA", int'(ramRdEnA), int'(e.en[0]));
      check(e.tag, "ramRdEnB", int'(ramRdEnB), int'(e.en[1]));
      check(e.tag, "ramWrEn", int'(ramWrEn), int'(e.en[2]));
      if (e.en[0]) check(e.tag, "ramRdAddrA", int'(ramRdAddrA), int'(e.addr[0]));
      if (e.en[1]) check(e.tag, "ramRdAddrB", int'(ramRdAddrB), int'(e.addr[1]));
      if (e.en[2]) check(e.tag, "ramWrAddr", int'(ramWrAddr), int'(e.addr[2]));
      check(e.tag, "rangeErr", int'(rangeErr), int'(e.err));
      check(e.tag, "cpValue", int'(cpValue), int'(e.cp));
    end
  end

  bit done = 0;
  initial begin
    #40000;
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [9:0] aliasAddr;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "ramRdEnA", int'(ramRdEnA), 0);
    check("R1", "ramRdEnB", int'(ramRdEnB), 0);
    check("R1", "ramWrEn", int'(ramWrEn), 0);
    check("R1", "rangeErr", int'(rangeErr), 0);
    check("R1", "cpValue", int'(cpValue), int'(BASE));
    rstN = 1'b1;
    monOn = 1;

    // R2: port A alone
    drive(1, 0, 0, 0, 0, 0, 0, 0, "R2");
    drive(1, 5, 0, 0, 0, 0, 0, 0, "R2");
    drive(1, 15, 0, 0, 0, 0, 0, 0, "R2");
    // R3: both read ports together
    drive(1, 3, 1, 12, 0, 0, 0, 0, "R3");
    drive(0, 0, 1, 9, 0, 0, 0, 0, "R3");
    // R4: write port, alone and with reads
    drive(0, 0, 0, 0, 1, 7, 0, 0, "R4");
    drive(1, 1, 1, 2, 1, 14, 0, 0, "R4");
    // R8: idle cycle
    idle("R8");
    // R5: base write with odd value, bit 0 cleared
    drive(0, 0, 0, 0, 0, 0, 1, 16'hF633, "R5");
    drive(1, 4, 0, 0, 0, 0, 0, 0, "R5");
    // R6: requests in the write cycle use the old base, next cycle the new
    drive(1, 2, 1, 6, 1, 8, 1, 16'hF800, "R6");
    drive(1, 2, 1, 6, 1, 8, 0, 0, "R6");
    // R7: window ending at the top of RAM, register 7 in, register 8 out
    drive(0, 0, 0, 0, 0, 0, 1, 16'hFDF0, "R7");
    drive(1, 7, 1, 8, 0, 0, 0, 0, "R7");
    drive(0, 0, 0, 0, 1, 15, 0, 0, "R7");
    // R7: window starting one word below RAM
    drive(0, 0, 0, 0, 0, 0, 1, 16'hF5FE, "R7");
    drive(1, 0, 1, 1, 1, 0, 0, 0, "R7");
    // R7: address past the top of the address space
    drive(0, 0, 0, 0, 0, 0, 1, 16'hFFF0, "R7");
    drive(0, 0, 1, 15, 0, 0, 0, 0, "R7");
    idle("R8");
    // R9: overlapping windows alias the same word
    drive(0, 0, 0, 0, 0, 0, 1, 16'hF640, "R9");
    drive(1, 10, 0, 0, 0, 0, 0, 0, "R9");
    @(posedge clk); #1; aliasAddr = ramRdAddrA;
    drive(0, 0, 0, 0, 0, 0, 1, 16'hF650, "R9");
    drive(0, 0, 1, 2, 0, 0, 0, 0, "R9");
    @(posedge clk); #1;
    check("R9", "alias ramRdAddrB", int'(ramRdAddrB), int'(aliasAddr));
    idle("R8");
    @(posedge clk); #2;
    check("R8", "queue drained", sbq.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule